// File: doc/BRIEF.md
# Cluster Power-Mode Sequencer

This controller sits on the SoC side of a cluster of up to four cores that share an L2 memory system. It moves the cluster from normal operation into one of two low-power modes and back again. In **shutdown** every domain is switched off: the cores, the cluster logic and the L2 RAMs. In **dormant** the cores and the cluster logic are switched off, but the L2 RAM domain stays powered so its contents survive. The RAM inputs are clamped for as long as the logic around them is unpowered.

Entry uses a two-level idle handshake. The controller first waits for every core idle flag. Only then does it raise the AXI-master inactivity request, and it then waits for the L2 idle acknowledgement. After that it clamps: the cluster output clamps for shutdown, or the L2 RAM input clamps for dormant. The next cycle it removes power. A wake input starts the return path. The controller holds the core and L2 resets low and enables all domains. It waits for power-good plus a minimum reset-hold time, releases the clamps, and releases the resets a fixed number of cycles later. It drops the inactivity request only once the L2 idle flag has fallen.

The L2 reset-disable stays low on a return from shutdown. On a return from dormant it is held high through the whole reset sequence, so that the retained cache contents are not wiped.

States: `ST_RUN`, `ST_CORE_WAIT`, `ST_L2_WAIT`, `ST_CLAMP`, `ST_OFF`, `ST_PWR_UP`, `ST_RST_HOLD`, `ST_UNCLAMP`, `ST_DRAIN`.

Transitions:
- `ST_RUN`→`ST_CORE_WAIT` on a shutdown or dormant code.
- `ST_CORE_WAIT`→`ST_L2_WAIT` when all cores are idle.
- `ST_L2_WAIT`→`ST_CLAMP` on L2 idle.
- `ST_CLAMP`→`ST_OFF` unconditionally.
- `ST_OFF`→`ST_PWR_UP` on wake.
- `ST_PWR_UP`→`ST_RST_HOLD` when all power-good inputs are high.
- `ST_RST_HOLD`→`ST_PWR_UP` if power-good drops.
- `ST_RST_HOLD`→`ST_UNCLAMP` after `RST_HOLD` cycles.
- `ST_UNCLAMP`→`ST_DRAIN` after `REL_DLY` cycles.
- `ST_DRAIN`→`ST_RUN` when L2 idle falls.

Top module: `cluster_pwr_ctrl`

## Requirements
- R1: After reset the block is in run: all power enables high, all resets released (high), both clamps low, inactivity request low, reset-disable low, `cur_mode`=00, `mode_err`=0, `done`=0.
- R2: Mode codes are 00 run, 01 shutdown, 10 dormant, 11 illegal. A 01 or 10 code in run starts entry. The inactivity request does not rise while any `core_idle` bit is low.
- R3: A clamp rises only after `l2_idle` has been seen high while the inactivity request was asserted. Before that, both clamps stay low and all domains stay powered.
- R4: Shutdown entry leaves `out_clamp`=1 and `ram_in_clamp`=0, with the core, cluster and RAM enables all 0. Power is never removed from a domain without a clamp active.
- R5: Dormant entry leaves `ram_in_clamp`=1 and `out_clamp`=0, with the core and cluster enables 0 and `pwr_ram_en`=1. The two clamps are never active together.
- R6: On wake all power enables rise while every core reset and the L2 reset are low. The reset-disable is 0 when returning from shutdown.
- R7: On a return from dormant, `l2_rst_dis` stays 1 from power-up until the block is back in run. It returns to 0 in run.
- R8: Clamps are released only after power-good has been high with resets held low for at least `RST_HOLD` (at least 4) cycles. A power-good drop restarts the wait.
- R9: Resets are released exactly `REL_DLY` cycles after the clamps are released.
- R10: Once raised, the inactivity request stays high until `l2_idle` has fallen. The block then returns to run.
- R11: `mode_req` is sampled only in run. Changes made during entry, in the off state or during exit have no effect.
- R12: Code 11 in run is ignored (the block stays in run, fully powered) and sets `mode_err`, which stays set until reset.
- R13: `done` is a one-cycle pulse when the off state is reached and when run is reached again. `cur_mode` takes the entered mode code with the first pulse and 00 with the second, and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_idle | input | NCORE | Per-core idle flags |
| l2_idle | input | 1 | L2 memory system idle acknowledgement |
| mode_req | input | 2 | Requested mode (00 run, 01 shutdown, 10 dormant) |
| wake | input | 1 | Start the return to run from the off state |
| pg_core | input | NCORE | Per-core domain power-good |
| pg_cluster | input | 1 | Cluster logic domain power-good |
| pg_ram | input | 1 | L2 RAM domain power-good |
| axi_inact_req | output | 1 | AXI-master inactivity request |
| out_clamp | output | 1 | Cluster output clamp enable |
| ram_in_clamp | output | 1 | L2 RAM input clamp enable |
| pwr_core_en | output | NCORE | Per-core domain power enable |
| pwr_cluster_en | output | 1 | Cluster logic domain power enable |
| pwr_ram_en | output | 1 | L2 RAM domain power enable |
| core_rst_n | output | NCORE | Per-core reset, active low |
| l2_rst_n | output | 1 | L2 reset, active low |
| l2_rst_dis | output | 1 | L2 cache hardware-reset disable |
| done | output | 1 | One-cycle completion pulse |
| cur_mode | output | 2 | Current mode code |
| mode_err | output | 1 | Sticky illegal-mode flag |

## Verification
On every cycle, the assertions check the ordering rules:
- the inactivity request never rises ahead of all-core idle;
- a clamp never rises without a prior L2 idle;
- power is never removed without a clamp, and the two clamps are never active together;
- the reset-disable level matches the mode during reset;
- the inactivity request never falls while L2 idle is high;
- clamp release never comes before the reset-hold window;
- `cur_mode` changes only with `done`, and `mode_err` is sticky.

Only the bench scenarios can show the rest. They show that the exact power pattern of each mode is reached and that resets follow the clamp release by exactly `REL_DLY` cycles. They also show that mode changes outside run are ignored and that the illegal code leaves the cluster powered.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_SHUT = 2'b01,
        MODE_DORM = 2'b10,
        MODE_BAD  = 2'b11
    } pmode_t;

    typedef enum logic [3:0] {
        ST_RUN       = 4'd0,
        ST_CORE_WAIT = 4'd1,
        ST_L2_WAIT   = 4'd2,
        ST_CLAMP     = 4'd3,
        ST_OFF       = 4'd4,
        ST_PWR_UP    = 4'd5,
        ST_RST_HOLD  = 4'd6,
        ST_UNCLAMP   = 4'd7,
        ST_DRAIN     = 4'd8
    } pstate_t;

    function automatic logic is_entry_code(input pmode_t m);
        return (m == MODE_SHUT) || (m == MODE_DORM);
    endfunction

endpackage

// File: rtl/cpm_reduce.sv
module cpm_reduce #(
    parameter int NCORE = 4
) (
    input  logic [NCORE-1:0] core_idle,
    input  logic [NCORE-1:0] pg_core,
    input  logic             pg_cluster,
    input  logic             pg_ram,
    output logic             all_idle,
    output logic             pg_all
);

    logic [NCORE:0] idle_chain;
    logic [NCORE:0] pg_chain;

    assign idle_chain[0] = 1'b1;
    assign pg_chain[0]   = pg_cluster & pg_ram;

    for (genvar g = 0; g < NCORE; g++) begin : g_core
        assign idle_chain[g+1] = idle_chain[g] & core_idle[g];
        assign pg_chain[g+1]   = pg_chain[g] & pg_core[g];
    end

    assign all_idle = idle_chain[NCORE];
    assign pg_all   = pg_chain[NCORE];

endmodule

// File: rtl/cpm_timer.sv
module cpm_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cpm_fsm.sv
module cpm_fsm
    import cpm_pkg::*;
#(
    parameter int RST_HOLD = 4,
    parameter int REL_DLY  = 3,
    parameter int CW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          all_idle,
    input  logic          pg_all,
    input  logic          l2_idle,
    input  logic [1:0]    mode_req,
    input  logic          wake,
    input  logic [CW-1:0] cnt,
    output logic          tmr_clr,
    output logic          inact_req,
    output logic          out_clamp,
    output logic          ram_clamp,
    output logic          core_pwr,
    output logic          clu_pwr,
    output logic          ram_pwr,
    output logic          core_rst_n_s,
    output logic          l2_rst_n,
    output logic          l2_rst_dis,
    output logic          done,
    output logic [1:0]    cur_mode,
    output logic          mode_err
);

    localparam logic [CW-1:0] HOLD_LAST = CW'(RST_HOLD - 1);
    localparam logic [CW-1:0] REL_LAST  = CW'(REL_DLY - 1);
    localparam logic [CW-1:0] HOLD_MIN  = CW'(RST_HOLD);

    pstate_t st, nxt;
    pmode_t  tgt;
    pmode_t  req_m;
    logic    is_dorm;
    logic    enter_off;
    logic    enter_run;

    assign req_m     = pmode_t'(mode_req);
    assign is_dorm   = (tgt == MODE_DORM);
    assign enter_off = (st == ST_CLAMP) && (nxt == ST_OFF);
    assign enter_run = (st == ST_DRAIN) && (nxt == ST_RUN);
    assign tmr_clr   = (st != nxt);

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_RUN:       if (is_entry_code(req_m)) nxt = ST_CORE_WAIT;
            ST_CORE_WAIT: if (all_idle)             nxt = ST_L2_WAIT;
            ST_L2_WAIT:   if (l2_idle)              nxt = ST_CLAMP;
            ST_CLAMP:                               nxt = ST_OFF;
            ST_OFF:       if (wake)                 nxt = ST_PWR_UP;
            ST_PWR_UP:    if (pg_all)               nxt = ST_RST_HOLD;
            ST_RST_HOLD: begin
                if (!pg_all)                nxt = ST_PWR_UP;
                else if (cnt == HOLD_LAST)  nxt = ST_UNCLAMP;
            end
            ST_UNCLAMP:   if (cnt == REL_LAST)      nxt = ST_DRAIN;
            ST_DRAIN:     if (!l2_idle)             nxt = ST_RUN;
            default:                                nxt = ST_RUN;
        endcase
    end

    // state register and registered status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_RUN;
            tgt      <= MODE_RUN;
            done     <= 1'b0;
            cur_mode <= MODE_RUN;
            mode_err <= 1'b0;
        end else begin
            st   <= nxt;
            done <= enter_off || enter_run;
            if (st == ST_RUN && nxt == ST_CORE_WAIT) tgt <= req_m;
            if (enter_off) cur_mode <= tgt;
            if (enter_run) cur_mode <= MODE_RUN;
            if (st == ST_RUN && req_m == MODE_BAD) mode_err <= 1'b1;
        end
    end

    // Moore outputs
    always_comb begin
        inact_req    = 1'b0;
        out_clamp    = 1'b0;
        ram_clamp    = 1'b0;
        core_pwr     = 1'b1;
        clu_pwr      = 1'b1;
        ram_pwr      = 1'b1;
        core_rst_n_s = 1'b1;
        l2_rst_n     = 1'b1;
        l2_rst_dis   = 1'b0;
        unique case (st)
            ST_RUN, ST_CORE_WAIT: begin
            end
            ST_L2_WAIT: begin
                inact_req = 1'b1;
            end
            ST_CLAMP: begin
                inact_req = 1'b1;
                out_clamp = !is_dorm;
                ram_clamp = is_dorm;
            end
            ST_OFF: begin
                inact_req    = 1'b1;
                out_clamp    = !is_dorm;
                ram_clamp    = is_dorm;
                core_pwr     = 1'b0;
                clu_pwr      = 1'b0;
                ram_pwr      = is_dorm;
                core_rst_n_s = 1'b0;
                l2_rst_n     = 1'b0;
                l2_rst_dis   = is_dorm;
            end
            ST_PWR_UP, ST_RST_HOLD: begin
                inact_req    = 1'b1;
                out_clamp    = !is_dorm;
                ram_clamp    = is_dorm;
                core_rst_n_s = 1'b0;
                l2_rst_n     = 1'b0;
                l2_rst_dis   = is_dorm;
            end
            ST_UNCLAMP: begin
                inact_req    = 1'b1;
                core_rst_n_s = 1'b0;
                l2_rst_n     = 1'b0;
                l2_rst_dis   = is_dorm;
            end
            ST_DRAIN: begin
                inact_req  = 1'b1;
                l2_rst_dis = is_dorm;
            end
            default: begin
            end
        endcase
    end

    // ---------------- assertions ----------------

    // support counter: cycles of good power with reset held
    logic [CW-1:0] hold_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (pg_all && !l2_rst_n) begin
            if (hold_cnt != HOLD_MIN) hold_cnt <= hold_cnt + 1'b1;
        end else begin
            hold_cnt <= '0;
        end
    end

    // R2
    inact_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_idle && !inact_req) |=> !inact_req);

    // R3
    clamp_after_l2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_clamp || ram_clamp) |-> $past(l2_idle && inact_req));

    // R4
    power_under_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clu_pwr || !core_pwr) |-> (out_clamp || ram_clamp));

    // R4
    ram_off_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_pwr |-> out_clamp);

    // R5
    clamp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_clamp, ram_clamp}));

    // R5
    ram_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_clamp |-> ram_pwr);

    // R6
    powerup_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clu_pwr) |-> (!l2_rst_n && !core_rst_n_s && (l2_rst_dis == ram_clamp)));

    // R7
    dorm_rst_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l2_rst_n && ram_clamp) |-> l2_rst_dis);

    // R7
    shut_rst_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l2_rst_n && out_clamp) |-> !l2_rst_dis);

    // R8
    clamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_clamp || ram_clamp) |-> (hold_cnt >= HOLD_MIN));

    // R10
    inact_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inact_req) |-> !$past(l2_idle));

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13
    mode_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_mode) |-> done);

endmodule

// File: rtl/cluster_pwr_ctrl.sv
module cluster_pwr_ctrl
    import cpm_pkg::*;
#(
    parameter int NCORE    = 4,
    parameter int RST_HOLD = 4,
    parameter int REL_DLY  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCORE-1:0] core_idle,
    input  logic             l2_idle,
    input  logic [1:0]       mode_req,
    input  logic             wake,
    input  logic [NCORE-1:0] pg_core,
    input  logic             pg_cluster,
    input  logic             pg_ram,
    output logic             axi_inact_req,
    output logic             out_clamp,
    output logic             ram_in_clamp,
    output logic [NCORE-1:0] pwr_core_en,
    output logic             pwr_cluster_en,
    output logic             pwr_ram_en,
    output logic [NCORE-1:0] core_rst_n,
    output logic             l2_rst_n,
    output logic             l2_rst_dis,
    output logic             done,
    output logic [1:0]       cur_mode,
    output logic             mode_err
);

    localparam int MAXD = (RST_HOLD > REL_DLY) ? RST_HOLD : REL_DLY;
    localparam int CW   = $clog2(MAXD + 1);

    logic          all_idle;
    logic          pg_all;
    logic          tmr_clr;
    logic [CW-1:0] cnt;
    logic          core_pwr;
    logic          core_rst_s;

    cpm_reduce #(.NCORE(NCORE)) u_reduce (
        .core_idle  (core_idle),
        .pg_core    (pg_core),
        .pg_cluster (pg_cluster),
        .pg_ram     (pg_ram),
        .all_idle   (all_idle),
        .pg_all     (pg_all)
    );

    cpm_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (cnt)
    );

    cpm_fsm #(.RST_HOLD(RST_HOLD), .REL_DLY(REL_DLY), .CW(CW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .all_idle     (all_idle),
        .pg_all       (pg_all),
        .l2_idle      (l2_idle),
        .mode_req     (mode_req),
        .wake         (wake),
        .cnt          (cnt),
        .tmr_clr      (tmr_clr),
        .inact_req    (axi_inact_req),
        .out_clamp    (out_clamp),
        .ram_clamp    (ram_in_clamp),
        .core_pwr     (core_pwr),
        .clu_pwr      (pwr_cluster_en),
        .ram_pwr      (pwr_ram_en),
        .core_rst_n_s (core_rst_s),
        .l2_rst_n     (l2_rst_n),
        .l2_rst_dis   (l2_rst_dis),
        .done         (done),
        .cur_mode     (cur_mode),
        .mode_err     (mode_err)
    );

    for (genvar g = 0; g < NCORE; g++) begin : g_fan
        assign pwr_core_en[g] = core_pwr;
        assign core_rst_n[g]  = core_rst_s;
    end

endmodule

// File: tb/cluster_pwr_ctrl_test.sv
`timescale 1ns/1ps
module cluster_pwr_ctrl_test;

    localparam int NCORE    = 4;
    localparam int RST_HOLD = 4;
    localparam int REL_DLY  = 3;

    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] early;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'b01, 4'b0111},
        '{2'b11, 4'b1111},
        '{2'b10, 4'b1010},
        '{2'b01, 4'b0000}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCORE-1:0] core_idle = '0;
    logic             l2_idle = 1'b0;
    logic [1:0]       mode_req = 2'b00;
    logic             wake = 1'b0;
    logic [NCORE-1:0] pg_core;
    logic             pg_cluster;
    logic             pg_ram;
    logic             axi_inact_req, out_clamp, ram_in_clamp;
    logic [NCORE-1:0] pwr_core_en, core_rst_n;
    logic             pwr_cluster_en, pwr_ram_en, l2_rst_n, l2_rst_dis;
    logic             done, mode_err;
    logic [1:0]       cur_mode;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // power supply model: power-good follows the enables two cycles later
    logic [NCORE+1:0] pg_d1 = '1;
    logic [NCORE+1:0] pg_d2 = '1;
    always_ff @(posedge clk) begin
        pg_d1 <= {pwr_cluster_en, pwr_ram_en, pwr_core_en};
        pg_d2 <= pg_d1;
    end
    assign pg_core    = pg_d2[NCORE-1:0];
    assign pg_ram     = pg_d2[NCORE];
    assign pg_cluster = pg_d2[NCORE+1];

    cluster_pwr_ctrl #(.NCORE(NCORE), .RST_HOLD(RST_HOLD), .REL_DLY(REL_DLY)) uut (
        .clk(clk), .rst_n(rst_n), .core_idle(core_idle), .l2_idle(l2_idle),
        .mode_req(mode_req), .wake(wake), .pg_core(pg_core), .pg_cluster(pg_cluster),
        .pg_ram(pg_ram), .axi_inact_req(axi_inact_req), .out_clamp(out_clamp),
        .ram_in_clamp(ram_in_clamp), .pwr_core_en(pwr_core_en),
        .pwr_cluster_en(pwr_cluster_en), .pwr_ram_en(pwr_ram_en),
        .core_rst_n(core_rst_n), .l2_rst_n(l2_rst_n), .l2_rst_dis(l2_rst_dis),
        .done(done), .cur_mode(cur_mode), .mode_err(mode_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_run_state(input string tag);
        chk({tag, " pwr core"}, 32'(pwr_core_en), 32'hF);
        chk({tag, " pwr cluster"}, 32'(pwr_cluster_en), 1);
        chk({tag, " pwr ram"}, 32'(pwr_ram_en), 1);
        chk({tag, " rst core"}, 32'(core_rst_n), 32'hF);
        chk({tag, " rst l2"}, 32'(l2_rst_n), 1);
        chk({tag, " clamps"}, {30'd0, out_clamp, ram_in_clamp}, 0);
        chk({tag, " inact"}, 32'(axi_inact_req), 0);
        chk({tag, " rst dis"}, 32'(l2_rst_dis), 0);
        chk({tag, " cur_mode"}, 32'(cur_mode), 0);
    endtask

    task automatic run_vec(input vec_t v);
        logic dorm;
        int   hold;
        int   rel;
        dorm = (v.mode == 2'b10);
        step(1);
        core_idle = v.early;
        mode_req  = v.mode;
        l2_idle   = 1'b0;
        if (v.mode == 2'b11) begin
            step(4);
            chk("R12 err set", 32'(mode_err), 1);
            check_run_state("R12 stays run");
            mode_req = 2'b00;
            step(2);
            chk("R12 err sticky", 32'(mode_err), 1);
            return;
        end
        step(5);
        chk("R2 inact low while cores busy", 32'(axi_inact_req), 0);
        core_idle = '1;
        step(3);
        chk("R2 inact after idle", 32'(axi_inact_req), 1);
        chk("R3 no clamp before l2 idle", {30'd0, out_clamp, ram_in_clamp}, 0);
        chk("R3 powered before l2 idle", 32'(pwr_cluster_en), 1);
        l2_idle = 1'b1;
        for (int i = 0; i < 50 && !done; i++) step(1);
        chk("R13 done on entry", 32'(done), 1);
        chk("R13 cur_mode entered", 32'(cur_mode), 32'(v.mode));
        chk("R10 inact held in off", 32'(axi_inact_req), 1);
        if (dorm) begin
            chk("R5 clamps", {30'd0, out_clamp, ram_in_clamp}, 1);
            chk("R5 pwr", {28'd0, pwr_cluster_en, pwr_ram_en, |pwr_core_en}, 32'b010);
        end else begin
            chk("R4 clamps", {30'd0, out_clamp, ram_in_clamp}, 2);
            chk("R4 pwr", {28'd0, pwr_cluster_en, pwr_ram_en, |pwr_core_en}, 0);
        end
        step(1);
        chk("R13 done single", 32'(done), 0);
        mode_req = dorm ? 2'b01 : 2'b10;
        step(4);
        chk("R11 mode ignored in off", 32'(cur_mode), 32'(v.mode));
        chk("R11 still off", 32'(pwr_cluster_en), 0);
        wake = 1'b1;
        step(1);
        wake = 1'b0;
        chk("R6 pwr up", {28'd0, pwr_cluster_en, pwr_ram_en, |pwr_core_en}, 32'b111);
        chk("R6 resets low", {27'd0, l2_rst_n, core_rst_n}, 0);
        chk("R6 R7 rst dis", 32'(l2_rst_dis), 32'(dorm));
        hold = 0;
        for (int i = 0; i < 50 && (out_clamp || ram_in_clamp); i++) begin
            if (pg_cluster && pg_ram && (&pg_core) && !l2_rst_n) hold++;
            if (dorm && l2_rst_dis !== 1'b1) chk("R7 dis during hold", 32'(l2_rst_dis), 1);
            step(1);
        end
        checks++;
        if (hold < RST_HOLD) begin
            errors++;
            $display("FAIL R8 hold cycles actual=%0d expected>=%0d", hold, RST_HOLD);
        end
        rel = 0;
        for (int i = 0; i < 50 && core_rst_n == '0; i++) begin
            step(1);
            rel++;
        end
        chk("R9 reset release delay", 32'(rel), 32'(REL_DLY));
        chk("R9 l2 reset released", 32'(l2_rst_n), 1);
        chk("R7 dis until run", 32'(l2_rst_dis), 32'(dorm));
        step(3);
        chk("R10 inact held while l2 idle", 32'(axi_inact_req), 1);
        l2_idle = 1'b0;
        for (int i = 0; i < 50 && !done; i++) step(1);
        chk("R13 done on exit", 32'(done), 1);
        check_run_state("R10 R13 back in run");
        core_idle = '0;
        mode_req  = 2'b00;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        check_run_state("R1 reset");
        chk("R1 err", 32'(mode_err), 0);
        chk("R1 done", 32'(done), 0);

        foreach (VECS[k]) run_vec(VECS[k]);

        // R11: dropping the request after entry starts has no effect
        mode_req = 2'b01;
        step(2);
        mode_req = 2'b00;
        core_idle = '1;
        step(3);
        chk("R11 entry continues", 32'(axi_inact_req), 1);
        // R1: reset mid-sequence returns to run
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(2);
        check_run_state("R1 mid reset");
        chk("R1 err cleared", 32'(mode_err), 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule